// File: doc/BRIEF.md
# Half-Duplex Serial Byte Port

This block moves bytes over a single serial wire that both ends share. The wire is pulled high by an external resistor. The block pulls it to a level only while `drive_en` is high; at all other times the wire floats and the block listens to it. One byte register is shared between the two directions:

- A host write places a byte in the register. The transmitter takes it as soon as it is idle.
- A received byte lands in the same register, and the host collects it with a one-clock read strobe.

Each frame on the wire is twelve bit times long:

- one low start bit;
- eight data bits, least significant first;
- one even-parity bit;
- two high stop bits.

The length of one bit time in system clocks comes from the `bit_clks` input. The receiver samples each bit near its middle. The receiver never looks for a start edge while the block drives the wire itself, so a port does not hear its own frames. A status byte reports four conditions:

- bit 0: the register is full;
- bit 5: a reception is running;
- bit 6: a written byte is waiting to be sent;
- bit 7: a transmission is running.

Top module: `hdx_uart`

## Requirements
- R1: After reset, `status` is 0, `drive_en` is low and `line_out` is high. Status bits 1 to 4 are always 0.
- R2: A clock edge with `wr_n` low stores `wr_data`. From the next cycle, status bit 0 (full) and status bit 6 (pending) are both high.
- R3: With the transmitter idle, the edge after a write moves the byte into the transmit shifter. From then on bits 0 and 6 are low, and bit 7 (tx busy) and `drive_en` are high.
- R4: While `drive_en` is high, `line_out` carries these bits in order: a low start bit, data bit 0 through data bit 7, the even-parity bit (XOR of the data bits), then two high stop bits.
- R5: Each bit lasts exactly `bit_clks` clocks (`bit_clks` must be at least 2). `drive_en` and status bit 7 fall exactly 12×`bit_clks` clocks after the shifter load.
- R6: A byte written while a frame is going out keeps bit 6 high until that frame ends. It then starts the next frame one clock later.
- R7: Status bit 5 is high while a frame is being received.
- R8: A complete received frame sets bit 0, with bit 6 low. A clock with `rd_n` low loads `rd_data` with the byte and clears bit 0.
- R9: While `drive_en` is high, no reception starts. After the block's own frame, bits 0 and 5 stay low.
- R10: Two ports on one wire exchange bytes in both directions intact, at more than one `bit_clks` setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bit_clks | input | DIV_W | Clocks per bit time |
| wr_data | input | 8 | Byte to send |
| wr_n | input | 1 | Active-low write strobe |
| rd_data | output | 8 | Byte returned by a read |
| rd_n | input | 1 | Active-low read strobe |
| status | output | 8 | Flags: 0 full, 5 rx busy, 6 tx pending, 7 tx busy |
| line_in | input | 1 | Level sensed on the shared wire |
| line_out | output | 1 | Level to drive when enabled |
| drive_en | output | 1 | Enables the external wire driver |

## Verification
The hardest situation to create from the ports is a port hearing its own frame on the shared wire. The bench wires two instances onto one resolved wire, so each `line_in` also sees that port's own `line_out`. It checks that the sender's full and rx-busy flags stay low during and after its frame, while the partner's rx-busy rises.

A second hard case is a write landing mid-frame. The bench writes a second byte part-way through a frame and checks two things: the pending flag holds until the frame ends, and the scoreboard receives both bytes in order. The bench also samples the wire at every bit midpoint against a frame it builds itself.

// File: rtl/hdx_uart.sv
module hdx_uart #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] bit_clks,
  input  logic [7:0]       wr_data,
  input  logic             wr_n,
  output logic [7:0]       rd_data,
  input  logic             rd_n,
  output logic [7:0]       status,
  input  logic             line_in,
  output logic             line_out,
  output logic             drive_en
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(11);
  localparam logic [CNT_W-1:0] PAR_BIT  = CNT_W'(9);
  localparam logic [CNT_W-1:0] STOP_BIT = CNT_W'(10);

  logic [7:0]       hold, rx_sh;
  logic             full, pend, tx_busy, rx_busy, s1, s2;
  logic [CNT_W-1:0] tx_bit, rx_bit;
  logic [DIV_W-1:0] tx_tick, rx_tick;
  logic [9:0]       tx_sh;

  wire tx_load = pend & ~tx_busy;
  wire tx_step = tx_busy && (tx_tick == bit_clks - 1'b1);
  wire rx_mid  = rx_busy && (rx_tick == (bit_clks >> 1));
  wire rx_done = rx_mid && (rx_bit == STOP_BIT);

  assign drive_en = tx_busy;
  assign line_out = !tx_busy || (tx_bit > PAR_BIT) || tx_sh[0];
  assign status   = {tx_busy, pend, rx_busy, 4'b0000, full};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold    <= '0;
      full    <= 1'b0;
      pend    <= 1'b0;
      rd_data <= '0;
    end else begin
      if (!wr_n) begin
        hold <= wr_data;
        full <= 1'b1;
        pend <= 1'b1;
      end else if (tx_load) begin
        full <= 1'b0;
        pend <= 1'b0;
      end else if (rx_done) begin
        hold <= rx_sh;
        full <= 1'b1;
      end else if (!rd_n) begin
        full <= 1'b0;
      end
      if (!rd_n) rd_data <= hold;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_bit  <= '0;
      tx_tick <= '0;
      tx_sh   <= '1;
    end else if (tx_load) begin
      tx_busy <= 1'b1;
      tx_bit  <= '0;
      tx_tick <= '0;
      tx_sh   <= {^hold, hold, 1'b0};
    end else if (tx_busy) begin
      if (tx_step) begin
        tx_tick <= '0;
        tx_sh   <= {1'b1, tx_sh[9:1]};
        if (tx_bit == LAST_BIT) tx_busy <= 1'b0;
        else                    tx_bit  <= tx_bit + 1'b1;
      end else begin
        tx_tick <= tx_tick + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      rx_busy <= 1'b0;
      rx_bit  <= '0;
      rx_tick <= '0;
      rx_sh   <= '0;
    end else begin
      s1 <= line_in;
      s2 <= s1;
      if (!rx_busy) begin
        if (!tx_busy && !s2) begin
          rx_busy <= 1'b1;
          rx_bit  <= '0;
          rx_tick <= '0;
        end
      end else begin
        if (rx_tick == bit_clks - 1'b1) begin
          rx_tick <= '0;
          rx_bit  <= rx_bit + 1'b1;
        end else begin
          rx_tick <= rx_tick + 1'b1;
        end
        if (rx_mid) begin
          if (rx_bit == '0 && s2)                          rx_busy <= 1'b0;
          else if (rx_bit != '0 && rx_bit < PAR_BIT)       rx_sh   <= {s2, rx_sh[7:1]};
          else if (rx_bit == STOP_BIT)                     rx_busy <= 1'b0;
        end
      end
    end
  end

  AST_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> full && pend); // R2
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !tx_busy && wr_n) |=> (tx_busy && !pend && !full)); // R3
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(tx_bit) == LAST_BIT); // R5
  AST_PEND_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && tx_busy && !tx_step) |=> pend); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && wr_n && !tx_load && !rx_done) |=> !full); // R8
  AST_NO_SELF_RX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_busy) |-> !$past(tx_busy)); // R9
endmodule

// File: tb/hdx_uart_test.sv
module hdx_uart_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bit_clks = 16'd16;
  logic [7:0] u_wd = '0, p_wd = '0;
  logic u_wr_n = 1'b1, p_wr_n = 1'b1, u_rd_n = 1'b1, p_rd_n = 1'b1;
  logic [7:0] u_rd, p_rd, u_st, p_st;
  logic u_out, p_out, u_en, p_en;
  wire line = (u_en ? u_out : 1'b1) & (p_en ? p_out : 1'b1);

  logic [7:0] q_peer[$];
  logic [7:0] q_uut[$];
  int n_cmp = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  hdx_uart #(.DIV_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .bit_clks(bit_clks), .wr_data(u_wd), .wr_n(u_wr_n),
    .rd_data(u_rd), .rd_n(u_rd_n), .status(u_st), .line_in(line),
    .line_out(u_out), .drive_en(u_en));

  hdx_uart #(.DIV_W(16)) peer (
    .clk(clk), .rst_n(rst_n), .bit_clks(bit_clks), .wr_data(p_wd), .wr_n(p_wr_n),
    .rd_data(p_rd), .rd_n(p_rd_n), .status(p_st), .line_in(line),
    .line_out(p_out), .drive_en(p_en));

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input bit from_peer, input logic [7:0] d);
    @(negedge clk);
    if (from_peer) begin q_uut.push_back(d);  p_wd = d; p_wr_n = 1'b0; end
    else           begin q_peer.push_back(d); u_wd = d; u_wr_n = 1'b0; end
    @(negedge clk);
    u_wr_n = 1'b1;
    p_wr_n = 1'b1;
  endtask

  task automatic wait_idle();
    do @(negedge clk);
    while (!(q_peer.size() == 0 && q_uut.size() == 0 && u_st[7:5] == 3'b0 &&
             p_st[7:5] == 3'b0 && !u_st[0] && !p_st[0]));
  endtask

  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (p_st[0] && !p_st[6]) begin
        p_rd_n = 1'b0;
        @(negedge clk);
        p_rd_n = 1'b1;
        check("R8 peer full cleared", int'(p_st[0]), 0);
        if (q_peer.size() == 0) check("R9 unexpected byte at peer", int'(p_rd), -1);
        else check("R10 byte at peer", int'(p_rd), int'(q_peer.pop_front()));
      end
    end
  end

  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (u_st[0] && !u_st[6]) begin
        u_rd_n = 1'b0;
        @(negedge clk);
        u_rd_n = 1'b1;
        check("R8 uut full cleared", int'(u_st[0]), 0);
        if (q_uut.size() == 0) check("R9 unexpected byte at uut", int'(u_rd), -1);
        else check("R10 byte at uut", int'(u_rd), int'(q_uut.pop_front()));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic exp_bit;
    repeat (5) @(negedge clk);
    check("R1 status reset", int'(u_st), 0);
    check("R1 drive_en reset", int'(u_en), 0);
    check("R1 line_out reset", int'(u_out), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    d = 8'h3B;
    q_peer.push_back(d);
    u_wd = d;
    u_wr_n = 1'b0;
    @(negedge clk);
    u_wr_n = 1'b1;
    check("R2 full after write", int'(u_st[0]), 1);
    check("R2 pending after write", int'(u_st[6]), 1);
    @(negedge clk);
    check("R3 flags after load", int'({u_st[7], u_st[6], u_st[0]}), 3'b100);
    check("R3 drive_en after load", int'(u_en), 1);
    repeat (8) @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      if (k == 0)      exp_bit = 1'b0;
      else if (k < 9)  exp_bit = d[k-1];
      else if (k == 9) exp_bit = ^d;
      else             exp_bit = 1'b1;
      check($sformatf("R4 frame bit %0d", k), int'(u_out), int'(exp_bit));
      if (k == 5) begin
        check("R7 peer rx busy", int'(p_st[5]), 1);
        check("R9 own rx idle", int'(u_st[5]), 0);
      end
      if (k < 11) repeat (16) @(negedge clk);
    end
    repeat (7) @(negedge clk);
    check("R5 still driving at last clock", int'(u_en), 1);
    @(negedge clk);
    check("R5 drive_en released", int'(u_en), 0);
    check("R5 tx busy cleared", int'(u_st[7]), 0);
    wait_idle();
    check("R9 no own byte", int'(u_st[0]), 0);

    send(1'b0, 8'hA5);
    repeat (40) @(negedge clk);
    send(1'b0, 8'h5A);
    check("R6 pending while busy", int'({u_st[7], u_st[6]}), 2'b11);
    do @(negedge clk); while (u_st[6]);
    check("R6 next frame started", int'(u_st[7]), 1);
    wait_idle();

    send(1'b1, 8'h55);
    wait_idle();
    send(1'b1, 8'h00);
    wait_idle();
    send(1'b1, 8'hFF);
    wait_idle();

    bit_clks = 16'd10;
    repeat (3) @(negedge clk);
    send(1'b0, 8'h81);
    wait_idle();
    send(1'b1, 8'h7E);
    wait_idle();
    check("R10 queues drained", q_peer.size() + q_uut.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule